// File: doc/BRIEF.md
# Trace End and Live-Output Predictor Table

This block learns, from the stream of committed instructions, where speculative traces end and which register values they leave behind. It cuts the committed stream into traces that are bounded by backward branches. A trace starts with the first instruction committed after a backward branch and ends with the next backward branch, within fixed length bounds. When a trace closes, the block writes a direct-mapped table entry keyed by the trace's start PC. The entry holds the PC at which the trace ended, up to four live-output registers with their last values and strides, and a short history of whether earlier predictions for that trace held.

A front end that wants to skip ahead presents a fetch PC on the lookup port. One cycle later the block returns a hit flag, the predicted end PC and the predicted live-output values (last value plus stride), together with a confidence count. Commits enter on a valid/ready stream. The block never applies back-pressure: `commit_ready` is held high, and a commit is consumed in every cycle where `commit_valid` is high. The lookup port is a plain strobe with a fixed one-cycle response.

Top module: `trace_end_predictor`

## Requirements
- R1: After reset every table entry is invalid, `rsp_valid` is low, `commit_ready` is high, and a lookup of any PC misses.
- R2: A lookup strobed at a clock edge answers with `rsp_valid` high at the following edge. PCs are word aligned (bits 1:0 zero). The entry index is PC bits [IDX_W+1:2] and the tag is the PC bits above them. `rsp_hit` is high only if the entry is valid and its tag equals the lookup tag.
- R3: Before the first backward branch, no trace is formed. After any backward branch, the next committed instruction starts a trace. That trace ends at the next backward branch, the branch included. The entry for the trace's start PC then holds the branch PC as its end PC.
- R4: If a backward branch closes a trace of fewer than MIN_LEN (8) instructions, counting the branch, the trace is dropped without a table write. The next instruction begins a new trace.
- R5: A trace that reaches MAX_LEN (64) instructions without a backward branch is closed at its 64th instruction, with that instruction's PC as the end PC. The following instruction starts a new trace.
- R6: A trace records up to NLIVE (4) distinct destination registers. They go into slots 0 to 3 in the order of their first write, and each slot keeps the last value written inside the trace. Response slot s sits at `rsp_live_rd[5s+4:5s]` and `rsp_live_val[32s+31:32s]`, with `rsp_live_mask[s]` marking it used. A fifth distinct register is ignored.
- R7: When a trace closes onto an entry with the same tag, each slot whose register ID is unchanged gets stride = new value − stored last value. Other slots, and newly allocated entries, get stride 0. The predicted value is last + stride.
- R8: Each entry keeps a 9-deep history of outcomes. An outcome is correct when every slot of the new trace matches the old entry's prediction and the slot masks agree. `rsp_conf` reports the number of correct outcomes in the history, and allocation clears the history.
- R9: A trace that closes onto a valid entry with a different tag replaces that entry. Lookups of the old start PC then miss.
- R10: A lookup in the same cycle as a table write to the same entry returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_valid | input | 1 | Committed instruction present |
| commit_ready | output | 1 | Always high; commits are never stalled |
| commit_pc | input | PC_W | PC of the committed instruction |
| commit_bwd | input | 1 | Instruction is a taken backward branch |
| commit_we | input | 1 | Instruction writes a register |
| commit_rd | input | 5 | Destination register ID |
| commit_data | input | DW | Value written to the destination |
| lk_valid | input | 1 | Lookup strobe |
| lk_pc | input | PC_W | Fetch PC to look up |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Entry valid with matching tag |
| rsp_end_pc | output | PC_W | Predicted trace end PC |
| rsp_live_mask | output | NLIVE | Used live-output slots |
| rsp_live_rd | output | NLIVE*5 | Live-output register IDs |
| rsp_live_val | output | NLIVE*DW | Predicted live-output values |
| rsp_conf | output | CONF_W | Count of correct outcomes in history |

## Verification
A table write and a lookup of the same entry can land on the same edge. The bench provokes this by strobing the lookup in the cycle right after the closing branch is accepted, which is exactly when the write commits. The first response must show a miss for a fresh entry, and a repeated lookup must then hit with the new end PC. A trace close and a tag replacement can also coincide, when a new trace maps onto an occupied index. The bench checks that the old start PC misses and the new one hits with a cleared history.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  localparam int RID_W = 5;
  typedef enum logic {ST_WAIT_BWD = 1'b0, ST_FORMING = 1'b1} form_st_e;
endpackage

// File: rtl/tbp_builder.sv
module tbp_builder
  import tbp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int DW      = 32,
  parameter int NLIVE   = 4,
  parameter int MIN_LEN = 8,
  parameter int MAX_LEN = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_fire,
  input  logic [PC_W-1:0]        in_pc,
  input  logic                   in_bwd,
  input  logic                   in_we,
  input  logic [RID_W-1:0]       in_rd,
  input  logic [DW-1:0]          in_data,
  output logic                   cl_valid,
  output logic [PC_W-1:0]        cl_start_pc,
  output logic [PC_W-1:0]        cl_end_pc,
  output logic [NLIVE-1:0]       cl_mask,
  output logic [NLIVE*RID_W-1:0] cl_rd,
  output logic [NLIVE*DW-1:0]    cl_val
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  form_st_e         st_q;
  logic [LEN_W-1:0] cnt_q, n_len, cl_len_q;
  logic [PC_W-1:0]  start_q, cur_start;
  logic [NLIVE-1:0] mask_q, m_mask;
  logic [RID_W-1:0] rd_q  [NLIVE];
  logic [RID_W-1:0] m_rd  [NLIVE];
  logic [DW-1:0]    val_q [NLIVE];
  logic [DW-1:0]    m_val [NLIVE];
  logic             found, placed, end_trace, do_close;

  // merge this instruction's register write into the live-output slots
  always_comb begin
    m_mask = mask_q;
    m_rd   = rd_q;
    m_val  = val_q;
    found  = 1'b0;
    for (int i = 0; i < NLIVE; i++) begin
      if (in_we && mask_q[i] && rd_q[i] == in_rd) begin
        m_val[i] = in_data;
        found    = 1'b1;
      end
    end
    placed = found || !in_we;
    for (int i = 0; i < NLIVE; i++) begin
      if (!placed && !mask_q[i]) begin
        m_mask[i] = 1'b1;
        m_rd[i]   = in_rd;
        m_val[i]  = in_data;
        placed    = 1'b1;
      end
    end
  end

  assign n_len     = cnt_q + 1'b1;
  assign cur_start = (cnt_q == '0) ? in_pc : start_q;
  assign end_trace = (st_q == ST_FORMING) && (in_bwd || n_len == LEN_W'(MAX_LEN));
  assign do_close  = in_fire && (st_q == ST_FORMING) &&
                     ((in_bwd && n_len >= LEN_W'(MIN_LEN)) || n_len == LEN_W'(MAX_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_WAIT_BWD;
      cnt_q       <= '0;
      start_q     <= '0;
      mask_q      <= '0;
      rd_q        <= '{default: '0};
      val_q       <= '{default: '0};
      cl_valid    <= 1'b0;
      cl_start_pc <= '0;
      cl_end_pc   <= '0;
      cl_len_q    <= '0;
      cl_mask     <= '0;
      cl_rd       <= '0;
      cl_val      <= '0;
    end else begin
      cl_valid <= do_close;
      if (do_close) begin
        cl_start_pc <= cur_start;
        cl_end_pc   <= in_pc;
        cl_len_q    <= n_len;
        cl_mask     <= m_mask;
        for (int i = 0; i < NLIVE; i++) begin
          cl_rd[i*RID_W +: RID_W] <= m_rd[i];
          cl_val[i*DW +: DW]      <= m_val[i];
        end
      end
      if (in_fire) begin
        if (st_q == ST_WAIT_BWD) begin
          if (in_bwd) begin
            st_q   <= ST_FORMING;
            cnt_q  <= '0;
            mask_q <= '0;
          end
        end else if (end_trace) begin
          cnt_q  <= '0;
          mask_q <= '0;
        end else begin
          cnt_q   <= n_len;
          start_q <= cur_start;
          mask_q  <= m_mask;
          rd_q    <= m_rd;
          val_q   <= m_val;
        end
      end
    end
  end

  AST_LEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cl_valid |-> (cl_len_q >= LEN_W'(MIN_LEN) && cl_len_q <= LEN_W'(MAX_LEN))); // R4
  AST_CNT_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < LEN_W'(MAX_LEN)); // R5
  AST_MASK_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & (mask_q + 1'b1)) == '0); // R6
  AST_CLOSE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    cl_valid |=> !cl_valid); // R4
  AST_NO_CLOSE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_BWD && in_fire) |=> !cl_valid); // R3
endmodule

// File: rtl/tbp_table.sv
module tbp_table
  import tbp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int DW      = 32,
  parameter int NLIVE   = 4,
  parameter int ENTRIES = 16,
  parameter int HIST    = 9,
  localparam int CONF_W = $clog2(HIST + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd_valid,
  input  logic [PC_W-1:0]        upd_pc,
  input  logic [PC_W-1:0]        upd_end_pc,
  input  logic [NLIVE-1:0]       upd_mask,
  input  logic [NLIVE*RID_W-1:0] upd_rd,
  input  logic [NLIVE*DW-1:0]    upd_val,
  input  logic                   lk_valid,
  input  logic [PC_W-1:0]        lk_pc,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic [PC_W-1:0]        rsp_end_pc,
  output logic [NLIVE-1:0]       rsp_live_mask,
  output logic [NLIVE*RID_W-1:0] rsp_live_rd,
  output logic [NLIVE*DW-1:0]    rsp_live_val,
  output logic [CONF_W-1:0]      rsp_conf
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic             v_q      [ENTRIES];
  logic [TAG_W-1:0] tag_q    [ENTRIES];
  logic [PC_W-1:0]  end_q    [ENTRIES];
  logic [NLIVE-1:0] mask_q   [ENTRIES];
  logic [RID_W-1:0] rd_q     [ENTRIES][NLIVE];
  logic [DW-1:0]    last_q   [ENTRIES][NLIVE];
  logic [DW-1:0]    stride_q [ENTRIES][NLIVE];
  logic [HIST-1:0]  hist_q   [ENTRIES];

  logic [IDX_W-1:0] u_idx, l_idx;
  logic [TAG_W-1:0] u_tag, l_tag;
  logic             old_hit, correct;
  logic [NLIVE-1:0] ok;
  logic [RID_W-1:0] n_rd     [NLIVE];
  logic [DW-1:0]    n_last   [NLIVE];
  logic [DW-1:0]    n_stride [NLIVE];
  logic [HIST-1:0]  n_hist;
  logic [DW-1:0]    pred     [NLIVE];

  assign u_idx   = upd_pc[IDX_W+1:2];
  assign u_tag   = upd_pc[PC_W-1:IDX_W+2];
  assign l_idx   = lk_pc[IDX_W+1:2];
  assign l_tag   = lk_pc[PC_W-1:IDX_W+2];
  assign old_hit = v_q[u_idx] && (tag_q[u_idx] == u_tag);

  // stride training and outcome evaluation for the entry being written
  always_comb begin
    for (int i = 0; i < NLIVE; i++) begin
      logic          same;
      logic [DW-1:0] nv;
      logic [RID_W-1:0] nr;
      nv   = upd_val[i*DW +: DW];
      nr   = upd_rd[i*RID_W +: RID_W];
      same = old_hit && upd_mask[i] && mask_q[u_idx][i] && (rd_q[u_idx][i] == nr);
      n_rd[i]     = upd_mask[i] ? nr : '0;
      n_last[i]   = upd_mask[i] ? nv : '0;
      n_stride[i] = same ? (nv - last_q[u_idx][i]) : '0;
      ok[i]       = upd_mask[i] ? (same && nv == last_q[u_idx][i] + stride_q[u_idx][i])
                                : !mask_q[u_idx][i];
    end
    correct = old_hit && (&ok);
    n_hist  = old_hit ? {hist_q[u_idx][HIST-2:0], correct} : '0;
  end

  for (genvar s = 0; s < NLIVE; s++) begin : g_pred
    assign pred[s] = last_q[l_idx][s] + stride_q[l_idx][s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        v_q[e]    <= 1'b0;
        tag_q[e]  <= '0;
        end_q[e]  <= '0;
        mask_q[e] <= '0;
        hist_q[e] <= '0;
        for (int i = 0; i < NLIVE; i++) begin
          rd_q[e][i]     <= '0;
          last_q[e][i]   <= '0;
          stride_q[e][i] <= '0;
        end
      end
    end else if (upd_valid) begin
      v_q[u_idx]    <= 1'b1;
      tag_q[u_idx]  <= u_tag;
      end_q[u_idx]  <= upd_end_pc;
      mask_q[u_idx] <= upd_mask;
      hist_q[u_idx] <= n_hist;
      for (int i = 0; i < NLIVE; i++) begin
        rd_q[u_idx][i]     <= n_rd[i];
        last_q[u_idx][i]   <= n_last[i];
        stride_q[u_idx][i] <= n_stride[i];
      end
    end
  end

  // registered lookup: reads state before any write on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_end_pc    <= '0;
      rsp_live_mask <= '0;
      rsp_live_rd   <= '0;
      rsp_live_val  <= '0;
      rsp_conf      <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && v_q[l_idx] && (tag_q[l_idx] == l_tag);
      if (lk_valid) begin
        rsp_end_pc    <= end_q[l_idx];
        rsp_live_mask <= mask_q[l_idx];
        rsp_conf      <= CONF_W'($countones(hist_q[l_idx]));
        for (int i = 0; i < NLIVE; i++) begin
          rsp_live_rd[i*RID_W +: RID_W] <= rd_q[l_idx][i];
          rsp_live_val[i*DW +: DW]      <= pred[i];
        end
      end
    end
  end

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid); // R2
  AST_LK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> lk_pc[1:0] == 2'b00); // R2
  AST_UPD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> upd_pc[1:0] == 2'b00); // R2
  AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> v_q[$past(u_idx)]); // R3
  AST_ALLOC_CLEARS_HIST: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !old_hit) |=> hist_q[$past(u_idx)] == '0); // R8
  AST_CONF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_conf <= CONF_W'(HIST)); // R8
endmodule

// File: rtl/trace_end_predictor.sv
module trace_end_predictor
  import tbp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int DW      = 32,
  parameter int NLIVE   = 4,
  parameter int ENTRIES = 16,
  parameter int MIN_LEN = 8,
  parameter int MAX_LEN = 64,
  parameter int HIST    = 9,
  localparam int CONF_W = $clog2(HIST + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit_valid,
  output logic                   commit_ready,
  input  logic [PC_W-1:0]        commit_pc,
  input  logic                   commit_bwd,
  input  logic                   commit_we,
  input  logic [RID_W-1:0]       commit_rd,
  input  logic [DW-1:0]          commit_data,
  input  logic                   lk_valid,
  input  logic [PC_W-1:0]        lk_pc,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic [PC_W-1:0]        rsp_end_pc,
  output logic [NLIVE-1:0]       rsp_live_mask,
  output logic [NLIVE*RID_W-1:0] rsp_live_rd,
  output logic [NLIVE*DW-1:0]    rsp_live_val,
  output logic [CONF_W-1:0]      rsp_conf
);
  logic                   fire;
  logic                   cl_valid;
  logic [PC_W-1:0]        cl_start_pc, cl_end_pc;
  logic [NLIVE-1:0]       cl_mask;
  logic [NLIVE*RID_W-1:0] cl_rd;
  logic [NLIVE*DW-1:0]    cl_val;

  assign commit_ready = 1'b1;
  assign fire         = commit_valid && commit_ready;

  tbp_builder #(
    .PC_W(PC_W), .DW(DW), .NLIVE(NLIVE), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) u_builder (
    .clk(clk), .rst_n(rst_n), .in_fire(fire), .in_pc(commit_pc), .in_bwd(commit_bwd),
    .in_we(commit_we), .in_rd(commit_rd), .in_data(commit_data),
    .cl_valid(cl_valid), .cl_start_pc(cl_start_pc), .cl_end_pc(cl_end_pc),
    .cl_mask(cl_mask), .cl_rd(cl_rd), .cl_val(cl_val)
  );

  tbp_table #(
    .PC_W(PC_W), .DW(DW), .NLIVE(NLIVE), .ENTRIES(ENTRIES), .HIST(HIST)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .upd_valid(cl_valid), .upd_pc(cl_start_pc),
    .upd_end_pc(cl_end_pc), .upd_mask(cl_mask), .upd_rd(cl_rd), .upd_val(cl_val),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_end_pc(rsp_end_pc), .rsp_live_mask(rsp_live_mask), .rsp_live_rd(rsp_live_rd),
    .rsp_live_val(rsp_live_val), .rsp_conf(rsp_conf)
  );

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R2
  AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> commit_ready); // R1
endmodule

// File: tb/tb_trace_end_predictor.sv
`timescale 1ns/1ps
module tb_trace_end_predictor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        commit_valid, commit_bwd, commit_we;
  logic        commit_ready;
  logic [31:0] commit_pc, commit_data;
  logic [4:0]  commit_rd;
  logic        lk_valid;
  logic [31:0] lk_pc;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_end_pc;
  logic [3:0]  rsp_live_mask;
  logic [19:0] rsp_live_rd;
  logic [127:0] rsp_live_val;
  logic [3:0]  rsp_conf;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  trace_end_predictor dut (
    .clk(clk), .rst_n(rst_n), .commit_valid(commit_valid), .commit_ready(commit_ready),
    .commit_pc(commit_pc), .commit_bwd(commit_bwd), .commit_we(commit_we),
    .commit_rd(commit_rd), .commit_data(commit_data), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_end_pc(rsp_end_pc),
    .rsp_live_mask(rsp_live_mask), .rsp_live_rd(rsp_live_rd),
    .rsp_live_val(rsp_live_val), .rsp_conf(rsp_conf)
  );

  // {start pc, length, ends with backward branch}
  localparam logic [39:0] VECS [0:7] = '{
    {32'h0000_1000, 7'd8,  1'b1},
    {32'h0000_2004, 7'd7,  1'b1},
    {32'h0000_3008, 7'd64, 1'b1},
    {32'h0000_400C, 7'd64, 1'b0},
    {32'h0000_5010, 7'd20, 1'b1},
    {32'h0000_6014, 7'd1,  1'b1},
    {32'h0000_7018, 7'd12, 1'b1},
    {32'h0000_801C, 7'd9,  1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic commit(input logic [31:0] pc, input logic bwd, input logic we,
                        input logic [4:0] rd, input logic [31:0] d);
    @(negedge clk);
    commit_valid = 1'b1; commit_pc = pc; commit_bwd = bwd;
    commit_we = we; commit_rd = rd; commit_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    commit_valid = 1'b0; commit_bwd = 1'b0; commit_we = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] pc);
    @(negedge clk);
    commit_valid = 1'b0; commit_bwd = 1'b0; commit_we = 1'b0;
    lk_valid = 1'b1; lk_pc = pc;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic run_trace(input logic [31:0] start, input int len, input bit bwd_end,
                           input logic [31:0] base, input bit writes);
    for (int k = 0; k < len; k++) begin
      logic       we;
      logic [4:0] rd;
      logic [31:0] d;
      we = writes && (k < 6);
      case (k)
        0: begin rd = 5'd5; d = base;     end
        1: begin rd = 5'd6; d = base + 1; end
        2: begin rd = 5'd5; d = base + 2; end
        3: begin rd = 5'd7; d = base + 3; end
        4: begin rd = 5'd8; d = base + 4; end
        5: begin rd = 5'd9; d = base + 5; end
        default: begin rd = 5'd0; d = 32'd0; end
      endcase
      commit(start + 32'(4 * k), bwd_end && (k == len - 1), we, rd, d);
    end
  endtask

  task automatic chk_live(input string req, input logic [31:0] base, input logic [31:0] step);
    logic [4:0]  erd [4];
    logic [31:0] ev  [4];
    erd = '{5'd5, 5'd6, 5'd7, 5'd8};
    ev  = '{base + 2 + step, base + 1 + step, base + 3 + step, base + 4 + step};
    chk(rsp_live_mask == 4'hF, req, "live mask", 64'(rsp_live_mask), 64'hF);
    for (int s = 0; s < 4; s++) begin
      chk(rsp_live_rd[s*5 +: 5] == erd[s], req, "live rd", 64'(rsp_live_rd[s*5 +: 5]), 64'(erd[s]));
      chk(rsp_live_val[s*32 +: 32] == ev[s], req, "live val", 64'(rsp_live_val[s*32 +: 32]), 64'(ev[s]));
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; commit_valid = 1'b0; commit_bwd = 1'b0; commit_we = 1'b0;
    commit_pc = '0; commit_rd = '0; commit_data = '0; lk_valid = 1'b0; lk_pc = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(commit_ready == 1'b1, "R1", "commit_ready", 64'(commit_ready), 64'd1);
    lookup(32'h0000_1000);
    chk(rsp_valid == 1'b1, "R2", "rsp_valid one cycle after lookup", 64'(rsp_valid), 64'd1);
    chk(rsp_hit == 1'b0, "R1", "hit after reset", 64'(rsp_hit), 64'd0);
    // R3: no trace before the first backward branch
    run_trace(32'h0000_0F00, 10, 1'b0, 32'd0, 1'b0);
    commit(32'h0000_0F28, 1'b1, 1'b0, 5'd0, 32'd0);
    idle();
    lookup(32'h0000_0F00);
    chk(rsp_hit == 1'b0, "R3", "hit before arming", 64'(rsp_hit), 64'd0);

    // vector table: trace lengths and closing kinds
    for (int v = 0; v < 8; v++) begin
      logic [31:0] st;
      int          len;
      bit          bwd, exp_hit;
      st = VECS[v][39:8]; len = int'(VECS[v][7:1]); bwd = VECS[v][0];
      exp_hit = bwd ? (len >= 8) : (len == 64);
      run_trace(st, len, bwd, 32'd0, 1'b0);
      idle();
      lookup(st);
      chk(rsp_hit == exp_hit, exp_hit ? "R3" : "R4", "vector hit", 64'(rsp_hit), 64'(exp_hit));
      if (exp_hit)
        chk(rsp_end_pc == st + 32'(4 * (len - 1)), bwd ? "R3" : "R5", "vector end pc",
            64'(rsp_end_pc), 64'(st + 32'(4 * (len - 1))));
    end

    // R6 / R7 / R8: live outputs, stride learning, confidence
    run_trace(32'h0000_9020, 10, 1'b1, 32'd100, 1'b1);
    idle(); lookup(32'h0000_9020);
    chk(rsp_hit == 1'b1, "R6", "live trace hit", 64'(rsp_hit), 64'd1);
    chk_live("R6", 32'd100, 32'd0);
    chk(rsp_conf == 4'd0, "R8", "conf after allocate", 64'(rsp_conf), 64'd0);
    run_trace(32'h0000_9020, 10, 1'b1, 32'd110, 1'b1);
    idle(); lookup(32'h0000_9020);
    chk_live("R7", 32'd110, 32'd10);
    chk(rsp_conf == 4'd0, "R8", "conf after wrong guess", 64'(rsp_conf), 64'd0);
    run_trace(32'h0000_9020, 10, 1'b1, 32'd120, 1'b1);
    idle(); lookup(32'h0000_9020);
    chk_live("R7", 32'd120, 32'd10);
    chk(rsp_conf == 4'd1, "R8", "conf after right guess", 64'(rsp_conf), 64'd1);

    // R9: same index, different tag replaces
    run_trace(32'h0001_9020, 8, 1'b1, 32'd0, 1'b0);
    idle(); lookup(32'h0001_9020);
    chk(rsp_hit == 1'b1, "R9", "new tag hit", 64'(rsp_hit), 64'd1);
    chk(rsp_conf == 4'd0, "R9", "replaced conf", 64'(rsp_conf), 64'd0);
    chk(rsp_live_mask == 4'h0, "R9", "replaced mask", 64'(rsp_live_mask), 64'd0);
    lookup(32'h0000_9020);
    chk(rsp_hit == 1'b0, "R9", "old tag miss", 64'(rsp_hit), 64'd0);

    // R10: lookup on the same edge as the write sees old contents
    run_trace(32'h0000_A024, 8, 1'b1, 32'd0, 1'b0);
    lookup(32'h0000_A024);
    chk(rsp_hit == 1'b0, "R10", "same-cycle lookup sees old", 64'(rsp_hit), 64'd0);
    lookup(32'h0000_A024);
    chk(rsp_hit == 1'b1, "R10", "later lookup hit", 64'(rsp_hit), 64'd1);
    chk(rsp_end_pc == 32'h0000_A040, "R10", "later end pc", 64'(rsp_end_pc), 64'h0000_A040);
    chk(commit_ready == 1'b1, "R1", "commit_ready stays high", 64'(commit_ready), 64'd1);
    idle();
    finish_run();
  end
endmodule